// File: doc/BRIEF.md
# Grain power-line gating controller

This block drives the supply line of every grain in a memory array whose cells are split, along each word line, into fixed-size grains with one power line each. A grain's line goes high only when its word line and its grain select are both active. Every other grain stays dark, except one that still owes a backup. In that case, after a write, the line stays up after the word line has dropped, long enough for the slow non-volatile pair to copy the fast volatile latch. Foreground writes run at the fast latch rate and never wait for that backup.

When a dark grain is powered again, the latch first has to be refilled from the non-volatile pair. The grain's ready flag is held low for a short restore window before access is allowed. Each grain runs its own four-state machine: OFF, RESTORE, ACTIVE and BACKUP. Each grain also has two independent down-timers: a short one for the restore window and a long one for the backup window. Both lengths are parameters counted in clock cycles. The grain width (8, 32 or 64 cells) is checked when the design is elaborated.

The transitions are as follows:
- OFF→RESTORE when the grain is selected.
- RESTORE→ACTIVE when the restore timer ends while the selection is still held. RESTORE→OFF if the selection drops during the restore window.
- ACTIVE→OFF on deselection of a grain that has not been written (a clean grain). ACTIVE→BACKUP on deselection of a grain that has been written (a dirty grain).
- BACKUP→ACTIVE (dirty) on a selected write.
- BACKUP→ACTIVE (clean) when the backup timer ends while the grain is selected. BACKUP→OFF when the backup timer ends while the grain is not selected.

Top module: `grain_power_ctrl`

## Requirements
- R1: Grain g = r*COLS + c has its power line raised only on the clock edge that follows a cycle with row_sel[r] and col_sel[c] both high. If several grains are selected this way at once, all of them power up.
- R2: A grain that is dark and not selected stays dark. Other grains may be selected or backing up at the same moment.
- R3: After its power line rises, a grain holds ready low for RESTORE_CYC cycles and raises it on the next edge while the selection is held. If the selection drops during that window, the power line falls on the next edge and ready is never raised.
- R4: A grain that is ready, not busy and deselected drops its power and ready flag on the next edge, and busy is never raised.
- R5: A write strobe sampled while the grain is selected and ready raises busy from the next edge. Busy stays high while the selection is held.
- R6: After a written grain is deselected, pwr_en, ready and busy stay high for exactly BACKUP_CYC cycles and then fall together. Busy is never high while the power line is low.
- R7: A selected write during a running backup keeps ready high, with no new restore. On the next deselection the backup window restarts at its full length.
- R8: A read-only selection during a running backup neither extends nor restarts the window. If the window ends while the grain is selected, the grain stays powered and ready, with busy low.
- R9: A write strobe while the grain is dark or restoring is ignored: busy stays low.
- R10: While rst_n is low, every pwr_en, ready and busy bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sel | input | ROWS | Word-line selects |
| col_sel | input | COLS | Grain (column) selects |
| wr_en | input | 1 | Write strobe for the selected grains |
| pwr_en | output | ROWS*COLS | Power-line enable per grain, index r*COLS+c |
| ready | output | ROWS*COLS | Grain latch valid and open for access |
| busy | output | ROWS*COLS | Backup owed or in progress |

## Verification
The hardest situations to reach are writes and reads that land inside a running backup window at a chosen count. The key case is a re-write part-way through the window, which must restart it. Another is a read held across the exact cycle in which the window expires. The stimulus table holds each input pattern for a stated number of cycles, so the deselection gap is counted to the cycle. Every case is then followed by a check at the point where a wrong timer length would already have changed the outputs. A second grain is started while the first is still backing up, which shows that the two grains' timers and power lines are kept apart.

// File: rtl/grain_pg_pkg.sv
package grain_pg_pkg;

    typedef enum logic [1:0] {
        PG_OFF     = 2'd0,
        PG_RESTORE = 2'd1,
        PG_ACTIVE  = 2'd2,
        PG_BACKUP  = 2'd3
    } pg_state_e;

    function automatic int unsigned timer_width(input int unsigned length);
        return (length < 2) ? 1 : $clog2(length + 1);
    endfunction

endpackage

// File: rtl/grain_select_matrix.sv
module grain_select_matrix #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 4,
    localparam int unsigned GRAINS = ROWS * COLS
) (
    input  logic [ROWS-1:0]   row_sel,
    input  logic [COLS-1:0]   col_sel,
    output logic [GRAINS-1:0] grain_hit
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign grain_hit[r*COLS + c] = row_sel[r] & col_sel[c];
        end
    end

endmodule

// File: rtl/grain_down_timer.sv
module grain_down_timer #(
    parameter int unsigned LENGTH = 16,
    localparam int unsigned W = grain_pg_pkg::timer_width(LENGTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= W'(LENGTH);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == W'(1));

endmodule

// File: rtl/grain_pg_fsm.sv
module grain_pg_fsm
    import grain_pg_pkg::*;
#(
    parameter int unsigned RESTORE_CYC = 1,
    parameter int unsigned BACKUP_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic wr_en,
    output logic pwr_en,
    output logic ready,
    output logic busy
);

    pg_state_e state_q, state_d;
    logic      dirty_q, dirty_d;
    logic      rst_start, rst_last;
    logic      bk_start, bk_last;
    logic      acc_write;

    assign acc_write = hit && wr_en;
    assign rst_start = (state_q == PG_OFF) && hit;
    assign bk_start  = (state_q == PG_ACTIVE) && !hit && dirty_q;

    grain_down_timer #(.LENGTH(RESTORE_CYC)) u_restore_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .run   (state_q == PG_RESTORE),
        .last  (rst_last)
    );

    grain_down_timer #(.LENGTH(BACKUP_CYC)) u_backup_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bk_start),
        .run   (state_q == PG_BACKUP),
        .last  (bk_last)
    );

    // Next-state and dirty-flag decision
    always_comb begin
        state_d = state_q;
        dirty_d = dirty_q;
        unique case (state_q)
            PG_OFF: begin
                dirty_d = 1'b0;
                if (hit) begin
                    state_d = PG_RESTORE;
                end
            end
            PG_RESTORE: begin
                dirty_d = 1'b0;
                if (!hit) begin
                    state_d = PG_OFF;
                end else if (rst_last) begin
                    state_d = PG_ACTIVE;
                end
            end
            PG_ACTIVE: begin
                if (!hit) begin
                    state_d = dirty_q ? PG_BACKUP : PG_OFF;
                end else if (acc_write) begin
                    dirty_d = 1'b1;
                end
            end
            PG_BACKUP: begin
                dirty_d = 1'b0;
                if (acc_write) begin
                    state_d = PG_ACTIVE;
                    dirty_d = 1'b1;
                end else if (bk_last) begin
                    state_d = hit ? PG_ACTIVE : PG_OFF;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_OFF;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            dirty_q <= dirty_d;
        end
    end

    // Outputs
    always_comb begin
        pwr_en = 1'b0;
        ready  = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            PG_OFF: begin
                pwr_en = 1'b0;
            end
            PG_RESTORE: begin
                pwr_en = 1'b1;
            end
            PG_ACTIVE: begin
                pwr_en = 1'b1;
                ready  = 1'b1;
                busy   = dirty_q;
            end
            PG_BACKUP: begin
                pwr_en = 1'b1;
                ready  = 1'b1;
                busy   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/grain_power_ctrl.sv
module grain_power_ctrl #(
    parameter int unsigned ROWS        = 4,
    parameter int unsigned COLS        = 4,
    parameter int unsigned GRAIN_CELLS = 64,
    parameter int unsigned RESTORE_CYC = 1,
    parameter int unsigned BACKUP_CYC  = 16,
    localparam int unsigned GRAINS     = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   row_sel,
    input  logic [COLS-1:0]   col_sel,
    input  logic              wr_en,
    output logic [GRAINS-1:0] pwr_en,
    output logic [GRAINS-1:0] ready,
    output logic [GRAINS-1:0] busy
);

    if (GRAIN_CELLS != 8 && GRAIN_CELLS != 32 && GRAIN_CELLS != 64) begin : g_bad_grain
        $error("GRAIN_CELLS must be 8, 32 or 64");
    end
    if (RESTORE_CYC < 1 || BACKUP_CYC < 1) begin : g_bad_timer
        $error("timer lengths must be at least one cycle");
    end

    logic [GRAINS-1:0] grain_hit;

    grain_select_matrix #(.ROWS(ROWS), .COLS(COLS)) u_select (
        .row_sel   (row_sel),
        .col_sel   (col_sel),
        .grain_hit (grain_hit)
    );

    for (genvar g = 0; g < GRAINS; g++) begin : g_grain
        grain_pg_fsm #(
            .RESTORE_CYC (RESTORE_CYC),
            .BACKUP_CYC  (BACKUP_CYC)
        ) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (grain_hit[g]),
            .wr_en  (wr_en),
            .pwr_en (pwr_en[g]),
            .ready  (ready[g]),
            .busy   (busy[g])
        );
    end

endmodule

// File: rtl/grain_power_ctrl_chk.sv
module grain_power_ctrl_chk #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 4,
    localparam int unsigned GRAINS = ROWS * COLS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROWS-1:0]   row_sel,
    input logic [COLS-1:0]   col_sel,
    input logic              wr_en,
    input logic [GRAINS-1:0] pwr_en,
    input logic [GRAINS-1:0] ready,
    input logic [GRAINS-1:0] busy
);

    assert_reset_dark_R10: assert property (@(posedge clk)
        !rst_n |=> (pwr_en == '0 && ready == '0 && busy == '0));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int unsigned G = r * COLS + c;

            assert_power_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pwr_en[G]) |-> $past(row_sel[r] && col_sel[c]));

            assert_idle_stays_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!pwr_en[G] && !(row_sel[r] && col_sel[c])) |=> !pwr_en[G]);

            assert_restore_before_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pwr_en[G]) |-> !ready[G]);

            assert_read_drops_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[G] && !busy[G] && !(row_sel[r] && col_sel[c])) |=> !pwr_en[G]);

            assert_write_marks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[G] && row_sel[r] && col_sel[c] && wr_en) |=> busy[G]);

            assert_busy_keeps_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
                busy[G] |-> (pwr_en[G] && ready[G]));

            assert_rewrite_no_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[G] && row_sel[r] && col_sel[c] && wr_en) |=> ready[G]);

            assert_early_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (!ready[G] && wr_en) |=> !busy[G]);
        end
    end

endmodule

bind grain_power_ctrl grain_power_ctrl_chk #(.ROWS(ROWS), .COLS(COLS)) i_grain_power_ctrl_chk (.*);

// File: tb/test_grain_power_ctrl.sv
module test_grain_power_ctrl;

    localparam int unsigned ROWS   = 4;
    localparam int unsigned COLS   = 4;
    localparam int unsigned GRAINS = ROWS * COLS;
    localparam int          WATCHDOG_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ROWS-1:0]   row_sel = '0;
    logic [COLS-1:0]   col_sel = '0;
    logic              wr_en = 1'b0;
    logic [GRAINS-1:0] pwr_en, ready, busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    grain_power_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .GRAIN_CELLS(64),
        .RESTORE_CYC(1), .BACKUP_CYC(16)
    ) i_grain_power_ctrl (
        .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .col_sel(col_sel),
        .wr_en(wr_en), .pwr_en(pwr_en), .ready(ready), .busy(busy)
    );

    // Vector: {row, col, wr, hold cycles, exp pwr_en, exp ready, exp busy}
    // Grain 5 = row 1 / col 1, grain 10 = row 2 / col 2, grain 4 = row 1 / col 0.
    localparam int NV = 33;
    localparam logic [64:0] VECS [NV] = '{
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}, //  0 idle
        {4'h2, 4'h2, 1'b0, 8'd1,  16'h0020, 16'h0000, 16'h0000}, //  1 R1 R3 power, no ready
        {4'h2, 4'h2, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0000}, //  2 R3 ready after restore
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}, //  3 R4 read-only drop
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0000, 16'h0000}, //  4 R9 write while dark
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0000}, //  5 R9 write while restoring
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0020}, //  6 R5 write when ready
        {4'h2, 4'h2, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, //  7 R5 busy held
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, //  8 R6 backup begins
        {4'h0, 4'h0, 1'b0, 8'd15, 16'h0020, 16'h0020, 16'h0020}, //  9 R6 last backup cycle
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}, // 10 R6 window over
        {4'h2, 4'h2, 1'b0, 8'd2,  16'h0020, 16'h0020, 16'h0000}, // 11
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 12
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 13
        {4'h0, 4'h0, 1'b0, 8'd5,  16'h0020, 16'h0020, 16'h0020}, // 14
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 15 R7 rewrite, ready kept
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 16
        {4'h0, 4'h0, 1'b0, 8'd15, 16'h0020, 16'h0020, 16'h0020}, // 17 R7 full window again
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}, // 18 R7
        {4'h2, 4'h2, 1'b0, 8'd2,  16'h0020, 16'h0020, 16'h0000}, // 19
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 20
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 21
        {4'h2, 4'h2, 1'b0, 8'd15, 16'h0020, 16'h0020, 16'h0020}, // 22 R8 read during backup
        {4'h2, 4'h2, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0000}, // 23 R8 expiry while selected
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}, // 24 R4
        {4'h2, 4'h2, 1'b0, 8'd2,  16'h0020, 16'h0020, 16'h0000}, // 25
        {4'h2, 4'h2, 1'b1, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 26
        {4'h4, 4'h4, 1'b0, 8'd1,  16'h0420, 16'h0020, 16'h0020}, // 27 R2 other grain, 6 and 9 dark
        {4'h4, 4'h4, 1'b0, 8'd1,  16'h0420, 16'h0420, 16'h0020}, // 28 R2
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0020, 16'h0020, 16'h0020}, // 29 R2
        {4'h0, 4'h0, 1'b0, 8'd14, 16'h0000, 16'h0000, 16'h0000}, // 30 R6
        {4'h2, 4'h3, 1'b0, 8'd1,  16'h0030, 16'h0000, 16'h0000}, // 31 R1 two grains on one row
        {4'h0, 4'h0, 1'b0, 8'd1,  16'h0000, 16'h0000, 16'h0000}  // 32 R3 abandoned restore
    };

    task automatic check(input string req, input string what,
                         input logic [GRAINS-1:0] act, input logic [GRAINS-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [GRAINS-1:0] ep,
                             input logic [GRAINS-1:0] er, input logic [GRAINS-1:0] eb);
        check(req, "pwr_en", pwr_en, ep);
        check(req, "ready",  ready,  er);
        check(req, "busy",   busy,   eb);
    endtask

    task automatic drive(input logic [3:0] r, input logic [3:0] c, input logic w, input int n);
        @(negedge clk);
        row_sel = r;
        col_sel = c;
        wr_en   = w;
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #2;
        check_all("R10", '0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [64:0] v;
            v = VECS[i];
            drive(v[64:61], v[60:57], v[56], int'(v[55:48]));
            check_all($sformatf("R%0d-vec%0d", 0, i), v[47:32], v[31:16], v[15:0]);
        end

        // R9 write strobe with no selection leaves everything dark
        drive(4'h0, 4'h0, 1'b1, 3);
        check_all("R9", '0, '0, '0);

        // R10 reset in the middle of a backup clears all outputs
        drive(4'h2, 4'h2, 1'b0, 2);
        drive(4'h2, 4'h2, 1'b1, 1);
        drive(4'h0, 4'h0, 1'b0, 3);
        check_all("R6", 16'h0020, 16'h0020, 16'h0020);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_all("R10", '0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'h0, 4'h0, 1'b0, 2);
        check_all("R10", '0, '0, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule